// File: doc/BRIEF.md
# Two-Port GPIO Controller with Pull-ups and Change Notification

This block controls two identical banks of general-purpose pins, port A and port B, sixteen pins each. Software sets each pin's direction and pull-up through a per-port control register that packs two bits per pin. It drives output levels through a per-port data register. Logic outside the block can also drive any pin through its own direction and data inputs. The block merges the three sources into a resolved pin level as a wired OR: CPU drive, peripheral drive, and the pull-up on pins that nobody drives.

Each write to a control or data register compares the resolved level of that port just before the write with the level just after it. When any pin changed, the block sends a one-cycle notify pulse to each enabled peripheral slot whose trigger mask for that port covers at least one changed pin. There are four slots. Each has an enable flag and one mask per port, all set over the same register bus. A further 16-bit interrupt-control register is stored and read back but does not act on the pins.

Top module: `gpio_pair_ctl`

## Requirements
- R1: In a port's 32-bit control register, bit 2n set makes pin n a CPU output, and bit 2n+1 set turns on the pull-up of pin n.
- R2: Each resolved pin equals (cpu_dir AND cpu_data) OR (per_dir AND per_data) OR (NOT(cpu_dir OR per_dir) AND pull-up), so a pin with no driver and no pull-up reads 0.
- R3: Register addresses are: 0 control A, 1 data A, 2 control B, 3 data B, 4 interrupt control, 5 slot enables (bit k enables slot k), 8+2k slot k mask for A, 9+2k slot k mask for B. Reads of addresses 1 and 3 return the resolved pins of that port. Every other register reads back the value last written, zero-extended.
- R4: A write to a control or data register that changes the resolved level of its port raises slot_notify[k] for exactly one cycle, in the cycle after the write. This happens only for an enabled slot k whose mask for that port ANDed with the changed pins is nonzero.
- R5: A write that leaves the resolved level of its port unchanged produces no notify pulse.
- R6: The ports are independent: a write to one port leaves the other port's pins unchanged and is matched only against the masks for the written port.
- R7: The interrupt-control register is a plain 16-bit read/write register; writing it changes no pin and raises no notify.
- R8: A slot whose enable bit is clear is never notified, whatever its masks hold.
- R9: Reset clears every control, data, interrupt-control, enable and mask register and all notify outputs, so with idle peripheral inputs every pin resolves to 0.
- R10: A change of the peripheral direction or data inputs alone never raises a notify pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| per_dir_a | input | 16 | Peripheral drive enables, port A |
| per_dat_a | input | 16 | Peripheral drive levels, port A |
| per_dir_b | input | 16 | Peripheral drive enables, port B |
| per_dat_b | input | 16 | Peripheral drive levels, port B |
| pins_a | output | 16 | Resolved pin levels, port A |
| pins_b | output | 16 | Resolved pin levels, port B |
| slot_notify | output | 4 | One-cycle change pulse per peripheral slot |

## Verification
The bench writes data to pins that are not outputs. A design that compared stored data rather than resolved levels would notify on these writes when it should stay quiet. It drives a CPU output low while a peripheral drives the same pin high, and clears a driven pin's pull-up. These cases catch a merge that lets the CPU win or that ignores peripheral direction when it applies the pull-up. It changes pins that only disabled slots, or only the other port's masks, cover, which exposes a design that ignores enable flags or mixes the two mask sets. It also holds the bus quiet while the peripheral inputs move, which catches a design that watches the pins directly.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTL_A = 4'd0,
        REG_DAT_A = 4'd1,
        REG_CTL_B = 4'd2,
        REG_DAT_B = 4'd3,
        REG_PIC   = 4'd4,
        REG_VLD   = 4'd5
    } reg_sel_e;

    // slot k: mask for port A at MASK_BASE+2k, port B at MASK_BASE+2k+1
    localparam logic [ADDR_W-1:0] MASK_BASE = 4'd8;
endpackage

// File: rtl/gpio_line_merge.sv
module gpio_line_merge #(
    parameter int PINS = 16
) (
    input  logic [2*PINS-1:0] ctl,
    input  logic [PINS-1:0]   cpu_dat,
    input  logic [PINS-1:0]   per_dir,
    input  logic [PINS-1:0]   per_dat,
    output logic [PINS-1:0]   line
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic out_en;
        logic pull_en;
        assign out_en  = ctl[2*i];
        assign pull_en = ctl[2*i+1];
        assign line[i] = (out_en & cpu_dat[i])
                       | (per_dir[i] & per_dat[i])
                       | (~(out_en | per_dir[i]) & pull_en);
    end
endmodule

// File: rtl/gpio_slot_hit.sv
module gpio_slot_hit #(
    parameter int PINS = 16
) (
    input  logic            enable,
    input  logic [PINS-1:0] mask_a,
    input  logic [PINS-1:0] mask_b,
    input  logic [PINS-1:0] chg_a,
    input  logic [PINS-1:0] chg_b,
    output logic            hit
);
    assign hit = enable & ((|(mask_a & chg_a)) | (|(mask_b & chg_b)));
endmodule

// File: rtl/gpio_pair_ctl.sv
module gpio_pair_ctl
    import gpio_pair_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int NSLOT = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2*PINS-1:0]   bus_wdata,
    output logic [2*PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]     per_dir_a,
    input  logic [PINS-1:0]     per_dat_a,
    input  logic [PINS-1:0]     per_dir_b,
    input  logic [PINS-1:0]     per_dat_b,
    output logic [PINS-1:0]     pins_a,
    output logic [PINS-1:0]     pins_b,
    output logic [NSLOT-1:0]    slot_notify
);
    localparam int CW    = 2 * PINS;
    localparam int NPORT = 2;

    typedef struct packed {
        logic [NPORT-1:0][CW-1:0]              ctl;
        logic [NPORT-1:0][PINS-1:0]            dat;
        logic [PINS-1:0]                       pic;
        logic [NSLOT-1:0]                      vld;
        logic [NSLOT-1:0][NPORT-1:0][PINS-1:0] mask;
    } state_t;

    state_t                     st_q, st_d;
    logic [NSLOT-1:0]           ntf_q, hit_d;
    logic [NPORT-1:0][PINS-1:0] per_dir_v, per_dat_v;
    logic [NPORT-1:0][PINS-1:0] line_cur, line_nxt, chg;
    logic [NSLOT-1:0]           slot_vld;

    assign per_dir_v = {per_dir_b, per_dir_a};
    assign per_dat_v = {per_dat_b, per_dat_a};
    assign slot_vld  = st_q.vld;

    // resolved level now, and the level the pending write would give
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_line_merge #(.PINS(PINS)) u_cur (
            .ctl     (st_q.ctl[p]),
            .cpu_dat (st_q.dat[p]),
            .per_dir (per_dir_v[p]),
            .per_dat (per_dat_v[p]),
            .line    (line_cur[p])
        );
        gpio_line_merge #(.PINS(PINS)) u_nxt (
            .ctl     (st_d.ctl[p]),
            .cpu_dat (st_d.dat[p]),
            .per_dir (per_dir_v[p]),
            .per_dat (per_dat_v[p]),
            .line    (line_nxt[p])
        );
        assign chg[p] = line_cur[p] ^ line_nxt[p];
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        gpio_slot_hit #(.PINS(PINS)) u_hit (
            .enable (st_q.vld[k]),
            .mask_a (st_q.mask[k][0]),
            .mask_b (st_q.mask[k][1]),
            .chg_a  (chg[0]),
            .chg_b  (chg[1]),
            .hit    (hit_d[k])
        );
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                REG_CTL_A: st_d.ctl[0] = bus_wdata;
                REG_DAT_A: st_d.dat[0] = bus_wdata[PINS-1:0];
                REG_CTL_B: st_d.ctl[1] = bus_wdata;
                REG_DAT_B: st_d.dat[1] = bus_wdata[PINS-1:0];
                REG_PIC:   st_d.pic    = bus_wdata[PINS-1:0];
                REG_VLD:   st_d.vld    = bus_wdata[NSLOT-1:0];
                default: begin
                    for (int k = 0; k < NSLOT; k++) begin
                        for (int p = 0; p < NPORT; p++) begin
                            if (bus_addr == MASK_BASE + ADDR_W'(2*k + p))
                                st_d.mask[k][p] = bus_wdata[PINS-1:0];
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTL_A: bus_rdata = st_q.ctl[0];
            REG_DAT_A: bus_rdata = CW'(line_cur[0]);
            REG_CTL_B: bus_rdata = st_q.ctl[1];
            REG_DAT_B: bus_rdata = CW'(line_cur[1]);
            REG_PIC:   bus_rdata = CW'(st_q.pic);
            REG_VLD:   bus_rdata = CW'(st_q.vld);
            default: begin
                for (int k = 0; k < NSLOT; k++) begin
                    for (int p = 0; p < NPORT; p++) begin
                        if (bus_addr == MASK_BASE + ADDR_W'(2*k + p))
                            bus_rdata = CW'(st_q.mask[k][p]);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            ntf_q <= '0;
        end else begin
            st_q  <= st_d;
            ntf_q <= hit_d;
        end
    end

    assign pins_a      = line_cur[0];
    assign pins_b      = line_cur[1];
    assign slot_notify = ntf_q;
endmodule

// File: rtl/gpio_pair_ctl_chk.sv
module gpio_pair_ctl_chk
    import gpio_pair_pkg::*;
#(
    parameter int PINS  = 16,
    parameter int NSLOT = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2*PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]     per_dir_a,
    input logic [PINS-1:0]     per_dat_a,
    input logic [PINS-1:0]     per_dir_b,
    input logic [PINS-1:0]     per_dat_b,
    input logic [PINS-1:0]     pins_a,
    input logic [PINS-1:0]     pins_b,
    input logic [NSLOT-1:0]    slot_notify,
    input logic [NSLOT-1:0]    slot_vld
);
    logic pin_write;
    assign pin_write = bus_wr && (bus_addr <= REG_DAT_B);

    a_r4_notify_after_pin_write: assert property (@(posedge clk) disable iff (rst)
        (|slot_notify) |-> $past(pin_write));

    a_r5_quiet_when_level_kept: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr) && $stable(pins_a) && $stable(pins_b)
         && $stable(per_dir_a) && $stable(per_dat_a)
         && $stable(per_dir_b) && $stable(per_dat_b)) |-> (slot_notify == '0));

    a_r7_pic_write_silent: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == REG_PIC) |-> (slot_notify == '0));

    a_r3_read_a_is_line: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_DAT_A) |-> (bus_rdata == (2*PINS)'(pins_a)));

    a_r3_read_b_is_line: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_DAT_B) |-> (bus_rdata == (2*PINS)'(pins_b)));

    a_r9_no_pulse_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_notify == '0));

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot_chk
        a_r8_enabled_slot_only: assert property (@(posedge clk) disable iff (rst)
            slot_notify[k] |-> $past(slot_vld[k]));
    end
endmodule

bind gpio_pair_ctl gpio_pair_ctl_chk #(.PINS(PINS), .NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .per_dir_a   (per_dir_a),
    .per_dat_a   (per_dat_a),
    .per_dir_b   (per_dir_b),
    .per_dat_b   (per_dat_b),
    .pins_a      (pins_a),
    .pins_b      (pins_b),
    .slot_notify (slot_notify),
    .slot_vld    (slot_vld)
);

// File: tb/gpio_pair_ctl_bench.sv
module gpio_pair_ctl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] per_dir_a = '0, per_dat_a = '0, per_dir_b = '0, per_dat_b = '0;
    logic [15:0] pins_a, pins_b;
    logic [3:0]  slot_notify;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_pair_ctl u_gpio_pair_ctl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_dir_a(per_dir_a), .per_dat_a(per_dat_a),
        .per_dir_b(per_dir_b), .per_dat_b(per_dat_b),
        .pins_a(pins_a), .pins_b(pins_b), .slot_notify(slot_notify)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // write lands at the posedge between the two negedges; notify is visible after
    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R9 pins_a after reset", 32'(pins_a), 32'h0);
        chk("R9 pins_b after reset", 32'(pins_b), 32'h0);
        chk("R9 notify after reset", 32'(slot_notify), 32'h0);
        rd(4'd0, v); chk("R9 control A cleared", v, 32'h0);
        rd(4'd4, v); chk("R9 irq control cleared", v, 32'h0);
        rd(4'd8, v); chk("R9 slot0 mask A cleared", v, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        // pin0 out, pin1 pull-up, pin2 out+pull-up
        wr(4'd0, 32'h0000_0039);
        chk("R1 decode, data 0", 32'(pins_a), 32'h0002);
        wr(4'd1, 32'h0000_FFFF);
        chk("R2 data ones, undriven pins low", 32'(pins_a), 32'h0007);
        rd(4'd1, v); chk("R3 data A read is resolved", v, 32'h0007);
        rd(4'd0, v); chk("R3 control A readback", v, 32'h0000_0039);
        wr(4'd1, 32'h0000_0000);
        chk("R1 output low beats own pull-up", 32'(pins_a), 32'h0002);
    endtask

    task automatic t_periph();
        logic [31:0] v;
        // ctl A 0x39, data A 0: slot 0 enabled, sensitive to all of port A
        wr(4'd8, 32'h0000_FFFF);
        wr(4'd5, 32'h0000_0001);
        @(negedge clk);
        per_dir_a = 16'h0002; per_dat_a = 16'h0000;
        #1 chk("R2 peripheral low cancels pull-up", 32'(pins_a), 32'h0000);
        chk("R10 no notify on peripheral change", 32'(slot_notify), 32'h0);
        @(negedge clk);
        per_dir_a = 16'h0101; per_dat_a = 16'h0101;
        #1 chk("R2 wired OR with CPU low output", 32'(pins_a), 32'h0103);
        rd(4'd1, v); chk("R3 read shows peripheral drive", v, 32'h0103);
        chk("R10 still no notify", 32'(slot_notify), 32'h0);
        idle_cycle();
        chk("R10 quiet one cycle later", 32'(slot_notify), 32'h0);
        @(negedge clk);
        per_dir_a = '0; per_dat_a = '0;
        wr(4'd5, 32'h0);
        wr(4'd8, 32'h0);
    endtask

    task automatic t_notify();
        logic [31:0] v;
        wr(4'd8,  32'h0001); wr(4'd9,  32'h0000);
        wr(4'd10, 32'hFFFF); wr(4'd11, 32'hFFFF);
        wr(4'd12, 32'h0004); wr(4'd13, 32'h0010);
        wr(4'd14, 32'h0000); wr(4'd15, 32'hFFFF);
        wr(4'd5,  32'h0005);
        rd(4'd12, v); chk("R3 slot2 mask A readback", v, 32'h0004);
        // pins_a is 0x0002 here
        wr(4'd1, 32'h0001);
        chk("R4 pin0 rise notifies slot0", 32'(slot_notify), 32'h1);
        chk("R4 pins_a after write", 32'(pins_a), 32'h0003);
        idle_cycle();
        chk("R4 pulse lasts one cycle", 32'(slot_notify), 32'h0);
        wr(4'd1, 32'h0005);
        chk("R4 pin2 rise notifies slot2 only", 32'(slot_notify), 32'h4);
        wr(4'd1, 32'h0005);
        chk("R5 same data, no notify", 32'(slot_notify), 32'h0);
        wr(4'd1, 32'h0105);
        chk("R5 data on input pin, no notify", 32'(slot_notify), 32'h0);
        wr(4'd0, 32'h0000_0031);
        chk("R4 change outside masks, no notify", 32'(slot_notify), 32'h0);
        chk("R4 pull-up removed", 32'(pins_a), 32'h0005);
        wr(4'd0, 32'h0000_0030);
        chk("R4 control write notifies slot0", 32'(slot_notify), 32'h1);
        chk("R4 pin0 released", 32'(pins_a), 32'h0004);
    endtask

    task automatic t_ports();
        wr(4'd2, 32'h0000_0100);
        chk("R5 control B no level change", 32'(slot_notify), 32'h0);
        wr(4'd3, 32'h0010);
        chk("R6 port B change uses B masks", 32'(slot_notify), 32'h4);
        chk("R6 pins_b driven", 32'(pins_b), 32'h0010);
        chk("R6 pins_a untouched", 32'(pins_a), 32'h0004);
        wr(4'd5, 32'h0007);
        wr(4'd3, 32'h0000);
        chk("R8 enabling slot1, slot3 stays off", 32'(slot_notify), 32'h6);
    endtask

    task automatic t_pic();
        logic [31:0] v;
        wr(4'd4, 32'h0000_A5A5);
        chk("R7 irq control write, no notify", 32'(slot_notify), 32'h0);
        chk("R7 pins_a unchanged", 32'(pins_a), 32'h0004);
        chk("R7 pins_b unchanged", 32'(pins_b), 32'h0000);
        rd(4'd4, v); chk("R7 irq control readback", v, 32'h0000_A5A5);
        rd(4'd5, v); chk("R3 enable readback", v, 32'h0000_0007);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_decode();
        t_periph();
        t_notify();
        t_ports();
        t_pic();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule